// File: doc/BRIEF.md
# Center-Aligned Complementary Half-Bridge Gate Generator

This block produces the two gate signals for one half-bridge leg. A triangular up-down counter sets the switching period. Two compare points sit symmetrically about the counter peak. The high-side gate is active during the up-count between the two points. The low-side gate is active during the down-count between the same two points. The dead time at the peak is the count distance between the upper compare and the peak, taken twice. The dead time at the valley is set by forcing both gates low at counter zero. No separate dead-band stage is used.

Software-style inputs supply a requested period and a half-width. The block rounds the period to an even value and limits the half-width so that a minimum gap always remains. The resulting period and compare pair is staged in shadow registers. All three values move to the active set together, and only at a counter-zero event after a one-shot load has been armed. A latched trip forces both gates low. The block comes out of reset already tripped. A sync pulse reloads the counter with a programmable phase so that a downstream delay can be offset. A registered flag reports any cycle in which both gates are high.

Top module: `hb_center_pwm`

## Requirements
- R1: The counter runs 0 up to the active period P, then back down to 0, and repeats. One full cycle of either gate therefore lasts 2P clock cycles.
- R2: The requested period is rounded down to an even value, P = 2*floor(period_in/2). For example, 201 behaves exactly like 200.
- R3: With half-period Ph = P/2 and effective half-width H, the compares are CA = Ph - H and CB = Ph + H. Gate A is high for 2H cycles in each period.
- R4: Gate A rises when the up-count reaches CA and falls when the up-count reaches CB. Gate B rises when the down-count reaches CB and falls when the down-count reaches CA. The time from A falling to B rising is 2(Ph - H). A is held low while counting down, and B is held low while counting up.
- R5: Both gates are low in the cycle after the counter is at zero.
- R6: H is limited to Ph - 25 when Ph > 25, and to 0 otherwise. A zero H gives no gate pulses.
- R7: Staged values go live only at a counter-zero event after load_arm has pulsed. The period and both compares change together. The arm is consumed by the transfer, so later input changes wait for a new arm.
- R8: trip_in high drives both gates low from the next cycle. The trip state stays latched after trip_in returns low.
- R9: After reset the block is tripped, and both gates stay low until the trip is cleared.
- R10: trip_clr releases the trip only in a cycle where trip_in is low. Gates resume only after the next counter-zero event.
- R11: A sync_in pulse loads the counter with phase_in (limited to P) and continues counting up. With a phase of 3, gate A rises CA - 3 + 1 cycles after the sync edge.
- R12: overlap is high exactly when both gates are high. It never fires for any sequence of period, width and sync updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_in | input | CW | Requested period in counts |
| half_in | input | CW | Requested half-width in counts |
| load_arm | input | 1 | One-cycle strobe arming the global shadow load |
| phase_in | input | CW | Counter value loaded on sync |
| sync_in | input | 1 | Sync pulse |
| trip_in | input | 1 | Trip request, latched |
| trip_clr | input | 1 | Trip clear request |
| out_a | output | 1 | High-side gate |
| out_b | output | 1 | Low-side gate |
| overlap | output | 1 | Both gates high in this cycle |

## Verification
A table of period and width pairs covers these cases:
- a plain setting;
- an odd period, which must behave exactly like its even neighbour;
- widths above the clamp at several periods, all of which must collapse to a 50-count gap;
- a period too short to allow any pulse.

Each pulse width, gap and repeat interval is measured edge to edge, so that every one of them separates a different term of the compare arithmetic.

Input changes are applied with and without the arm strobe to show that transfer waits for both the arm and zero. A sync placed at a known counter state times the phase load exactly. A trip cleared together with a sync shows whether resumption waits for the following zero or starts early.

Random period, width and sync sequences are used to look for any overlap.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/hbpwm_shadow.sv
module hbpwm_shadow #(
  parameter int CW         = 16,
  parameter int GAP        = 25,
  parameter int RST_PERIOD = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] half_in,
  input  logic          load_arm,
  input  logic          at_zero,
  output logic [CW-1:0] prd_act,
  output logic [CW-1:0] cmpa_act,
  output logic [CW-1:0] cmpb_act
);
  localparam logic [CW-1:0] GAP_C    = CW'(GAP);
  localparam logic [CW-1:0] RST_HALF = CW'(RST_PERIOD / 2);

  logic [CW-1:0] half_raw, per_half, h_lim, h_eff;
  logic [CW-1:0] sh_prd, sh_cmpa, sh_cmpb;
  logic          armed, xfer;

  // even period, limited half-width, symmetric compares
  always_comb begin
    half_raw = period_in >> 1;
    per_half = (half_raw == '0) ? CW'(1) : half_raw;
    h_lim    = (per_half > GAP_C) ? per_half - GAP_C : '0;
    h_eff    = (half_in > h_lim) ? h_lim : half_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_prd  <= RST_HALF << 1;
      sh_cmpa <= RST_HALF;
      sh_cmpb <= RST_HALF;
    end else begin
      sh_prd  <= per_half << 1;
      sh_cmpa <= per_half - h_eff;
      sh_cmpb <= per_half + h_eff;
    end
  end

  assign xfer = armed & at_zero;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= load_arm | (armed & ~xfer);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_act  <= RST_HALF << 1;
      cmpa_act <= RST_HALF;
      cmpb_act <= RST_HALF;
    end else if (xfer) begin
      prd_act  <= sh_prd;
      cmpa_act <= sh_cmpa;
      cmpb_act <= sh_cmpb;
    end
  end

  assert_load_only_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !at_zero |=> ($stable(prd_act) && $stable(cmpa_act) && $stable(cmpb_act)));
  assert_arm_consumed_R7: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (armed == $past(load_arm)));
  assert_even_period_R2: assert property (@(posedge clk) disable iff (rst)
    prd_act[0] == 1'b0);
  assert_symmetric_R3: assert property (@(posedge clk) disable iff (rst)
    (cmpa_act + cmpb_act) == prd_act);
endmodule

// File: rtl/hbpwm_timebase.sv
module hbpwm_timebase
  import hbpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] prd,
  input  logic          sync_in,
  input  logic [CW-1:0] phase_in,
  output logic [CW-1:0] ctr,
  output cnt_dir_e      dir,
  output logic          at_zero
);
  cnt_dir_e      ndir;
  logic [CW-1:0] nctr, phase_lim;

  always_comb begin
    ndir = dir;
    if (dir == DIR_UP && ctr >= prd)        ndir = DIR_DOWN;
    else if (dir == DIR_DOWN && ctr == '0)  ndir = DIR_UP;
    nctr      = (ndir == DIR_UP) ? ctr + 1'b1 : ctr - 1'b1;
    phase_lim = (phase_in > prd) ? prd : phase_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr <= '0;
      dir <= DIR_UP;
    end else if (sync_in) begin
      ctr <= phase_lim;
      dir <= DIR_UP;
    end else begin
      ctr <= nctr;
      dir <= ndir;
    end
  end

  assign at_zero = (ctr == '0);

  assert_ctr_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    ctr <= prd);
  assert_unit_step_R1: assert property (@(posedge clk) disable iff (rst)
    !sync_in |=> (ctr == $past(ctr) + 1'b1 || ctr == $past(ctr) - 1'b1));
  assert_sync_counts_up_R11: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> (dir == DIR_UP));
endmodule

// File: rtl/hbpwm_trip.sv
module hbpwm_trip #(
  parameter bit TRIP_AT_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_in,
  input  logic trip_clr,
  input  logic at_zero,
  output logic block
);
  logic trip_q, run_q;

  always_ff @(posedge clk) begin
    if (rst)           trip_q <= TRIP_AT_RESET;
    else if (trip_in)  trip_q <= 1'b1;
    else if (trip_clr) trip_q <= 1'b0;
  end

  // gates stay parked until the first zero after release
  always_ff @(posedge clk) begin
    if (rst)                    run_q <= 1'b0;
    else if (trip_q || trip_in) run_q <= 1'b0;
    else if (at_zero)           run_q <= 1'b1;
  end

  assign block = trip_q | trip_in | ~run_q;

  assert_trip_latches_R8: assert property (@(posedge clk) disable iff (rst)
    trip_in |=> trip_q);
  assert_trip_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (trip_q && !trip_clr) |=> trip_q);
  assert_resume_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(at_zero));
endmodule

// File: rtl/hbpwm_action.sv
module hbpwm_action
  import hbpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ctr,
  input  cnt_dir_e      dir,
  input  logic          at_zero,
  input  logic [CW-1:0] cmpa,
  input  logic [CW-1:0] cmpb,
  input  logic          block,
  output logic          a_q,
  output logic          b_q,
  output logic          both_q
);
  logic a_n, b_n;

  always_comb begin
    a_n = a_q;
    b_n = b_q;
    if (block || at_zero) begin
      a_n = 1'b0;
      b_n = 1'b0;
    end else if (dir == DIR_UP) begin
      b_n = 1'b0;
      if (ctr == cmpb)      a_n = 1'b0;
      else if (ctr == cmpa) a_n = 1'b1;
    end else begin
      a_n = 1'b0;
      if (ctr == cmpa)      b_n = 1'b0;
      else if (ctr == cmpb) b_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      both_q <= 1'b0;
    end else begin
      a_q    <= a_n;
      b_q    <= b_n;
      both_q <= a_n & b_n;
    end
  end

  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (rst)
    !(a_q && b_q));
  assert_flag_matches_R12: assert property (@(posedge clk) disable iff (rst)
    both_q == (a_q && b_q));
  assert_zero_low_R5: assert property (@(posedge clk) disable iff (rst)
    at_zero |=> (!a_q && !b_q));
  assert_blocked_low_R8: assert property (@(posedge clk) disable iff (rst)
    block |=> (!a_q && !b_q));
  assert_a_low_down_R4: assert property (@(posedge clk) disable iff (rst)
    (dir == DIR_DOWN) |=> !a_q);
  assert_b_low_up_R4: assert property (@(posedge clk) disable iff (rst)
    (dir == DIR_UP) |=> !b_q);
endmodule

// File: rtl/hb_center_pwm.sv
module hb_center_pwm
  import hbpwm_pkg::*;
#(
  parameter int CW            = 16,
  parameter int GAP           = 25,
  parameter int RST_PERIOD    = 200,
  parameter bit TRIP_AT_RESET = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] half_in,
  input  logic          load_arm,
  input  logic [CW-1:0] phase_in,
  input  logic          sync_in,
  input  logic          trip_in,
  input  logic          trip_clr,
  output logic          out_a,
  output logic          out_b,
  output logic          overlap
);
  logic [CW-1:0] prd_act, cmpa_act, cmpb_act, ctr;
  cnt_dir_e      dir;
  logic          at_zero, block;

  hbpwm_shadow #(.CW(CW), .GAP(GAP), .RST_PERIOD(RST_PERIOD)) u_shadow (
    .clk(clk), .rst(rst), .period_in(period_in), .half_in(half_in),
    .load_arm(load_arm), .at_zero(at_zero),
    .prd_act(prd_act), .cmpa_act(cmpa_act), .cmpb_act(cmpb_act)
  );

  hbpwm_timebase #(.CW(CW)) u_timebase (
    .clk(clk), .rst(rst), .prd(prd_act), .sync_in(sync_in),
    .phase_in(phase_in), .ctr(ctr), .dir(dir), .at_zero(at_zero)
  );

  hbpwm_trip #(.TRIP_AT_RESET(TRIP_AT_RESET)) u_trip (
    .clk(clk), .rst(rst), .trip_in(trip_in), .trip_clr(trip_clr),
    .at_zero(at_zero), .block(block)
  );

  hbpwm_action #(.CW(CW)) u_action (
    .clk(clk), .rst(rst), .ctr(ctr), .dir(dir), .at_zero(at_zero),
    .cmpa(cmpa_act), .cmpb(cmpb_act), .block(block),
    .a_q(out_a), .b_q(out_b), .both_q(overlap)
  );
endmodule

// File: tb/hb_center_pwm_tb.sv
module hb_center_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 16;
  localparam int NV         = 8;
  localparam int VP [NV] = '{200, 201, 200,  60, 300, 101,  40, 100};
  localparam int VH [NV] = '{ 40,  40,  90,  10, 125,  30,   3,   0};
  localparam int VW [NV] = '{ 80,  80, 150,  10, 250,  50,   0,   0};
  localparam int VG [NV] = '{120, 120,  50,  50,  50,  50,   0,   0};
  localparam int VT [NV] = '{400, 400, 400, 120, 600, 200,  80, 200};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] period_in = 16'd200, half_in = '0, phase_in = 16'd3;
  logic load_arm = 1'b0, sync_in = 1'b0, trip_in = 1'b0, trip_clr = 1'b0;
  logic out_a, out_b, overlap;

  int cyc = 0, checks = 0, failures = 0;
  int ov_cnt = 0, flag_bad = 0;
  bit mon_en = 1'b0;

  hb_center_pwm #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .period_in(period_in), .half_in(half_in),
    .load_arm(load_arm), .phase_in(phase_in), .sync_in(sync_in),
    .trip_in(trip_in), .trip_clr(trip_clr),
    .out_a(out_a), .out_b(out_b), .overlap(overlap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_en) begin
      if (out_a && out_b) ov_cnt++;
      if (overlap !== (out_a && out_b)) flag_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_lvl(input int which, input logic lvl, output int t);
    int n = 0;
    t = -1;
    while (n < 4000) begin
      @(negedge clk);
      if (((which == 0) ? out_a : out_b) === lvl) begin
        t = cyc;
        break;
      end
      n++;
    end
  endtask

  task automatic edge_at(input int which, input logic to_lvl, output int t);
    int dummy;
    wait_lvl(which, ~to_lvl, dummy);
    wait_lvl(which, to_lvl, t);
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (out_a || out_b) c++;
    end
  endtask

  task automatic arm_load(input int p, input int h);
    period_in = CW'(p);
    half_in   = CW'(h);
    idle(2);
    load_arm = 1'b1;
    idle(1);
    load_arm = 1'b0;
  endtask

  task automatic measure_rep(output int t);
    int t0, t1;
    edge_at(0, 1'b1, t0);
    edge_at(0, 1'b1, t1);
    t = t1 - t0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=%0d expected=finished", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c, t0, t1, t2, t3, t4, tE, rep;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);
    mon_en = 1'b1;
    chk(out_a == 1'b0 && out_b == 1'b0, "R9", "gates after reset", {out_a, out_b}, 0);
    chk(overlap == 1'b0, "R12", "flag after reset", overlap, 0);

    // R9: tripped from reset even with a valid loaded setting
    arm_load(200, 40);
    count_high(1000, c);
    chk(c == 0, "R9", "high cycles while tripped at start", c, 0);

    // R10: release; pulses must appear
    trip_clr = 1'b1; idle(1); trip_clr = 1'b0;
    wait_lvl(0, 1'b1, t0);
    chk(t0 >= 0, "R10", "gate A resumes after clear", t0 >= 0, 1);

    // table walk: R1 R2 R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      arm_load(VP[i], VH[i]);
      idle(1400);
      if (VW[i] == 0) begin
        count_high(2 * VT[i], c);
        chk(c == 0, "R6", $sformatf("vec%0d no pulse", i), c, 0);
      end else begin
        edge_at(0, 1'b1, t0);
        wait_lvl(0, 1'b0, t1);
        wait_lvl(1, 1'b1, t2);
        wait_lvl(1, 1'b0, t3);
        wait_lvl(0, 1'b1, t4);
        chk(t1 - t0 == VW[i], "R3", $sformatf("vec%0d A width", i), t1 - t0, VW[i]);
        chk(t2 - t1 == VG[i], "R6", $sformatf("vec%0d peak gap (R4)", i), t2 - t1, VG[i]);
        chk(t3 - t2 == VW[i], "R4", $sformatf("vec%0d B width", i), t3 - t2, VW[i]);
        chk(t4 - t0 == VT[i], "R2", $sformatf("vec%0d repeat (R1)", i), t4 - t0, VT[i]);
      end
    end

    // R7: arm gating and consumption
    arm_load(200, 40);
    idle(1400);
    period_in = 16'd300;
    idle(1400);
    measure_rep(rep);
    chk(rep == 400, "R7", "no arm keeps period", rep, 400);
    load_arm = 1'b1; idle(1); load_arm = 1'b0;
    idle(1400);
    measure_rep(rep);
    chk(rep == 600, "R7", "armed load takes period", rep, 600);
    period_in = 16'd200;
    idle(1400);
    measure_rep(rep);
    chk(rep == 600, "R7", "arm consumed after load", rep, 600);
    load_arm = 1'b1; idle(1); load_arm = 1'b0;
    idle(1400);
    measure_rep(rep);
    chk(rep == 400, "R7", "second arm reloads", rep, 400);

    // R11: sync right after A falls (counter CB+1 counting up), CA=60
    edge_at(0, 1'b0, t0);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    tE = cyc;
    wait_lvl(0, 1'b1, t1);
    chk(t1 - tE == 58, "R11", "A rise after sync", t1 - tE, 58);

    // R8: trip forces low and latches
    idle(37);
    trip_in = 1'b1;
    @(negedge clk);
    chk(!out_a && !out_b, "R8", "gates low after trip", {out_a, out_b}, 0);
    idle(3);
    trip_in = 1'b0;
    count_high(900, c);
    chk(c == 0, "R8", "trip stays latched", c, 0);

    // R10: clear ignored while trip_in high
    trip_in = 1'b1; trip_clr = 1'b1;
    idle(1);
    trip_in = 1'b0; trip_clr = 1'b0;
    count_high(900, c);
    chk(c == 0, "R10", "clear with trip high ignored", c, 0);

    // R10: clear together with sync (counter at 3 up); resume waits one zero
    sync_in = 1'b1; trip_clr = 1'b1;
    @(negedge clk);
    sync_in = 1'b0; trip_clr = 1'b0;
    tE = cyc;
    wait_lvl(0, 1'b1, t1);
    chk(t1 - tE == 458, "R10", "resume only after next zero", t1 - tE, 458);

    // R5: at zero both low: A and B never straddle the valley
    edge_at(1, 1'b0, t0);
    wait_lvl(0, 1'b1, t1);
    chk(t1 - t0 == 120, "R5", "valley gap B fall to A rise", t1 - t0, 120);

    // R12: random updates and syncs
    for (int k = 0; k < 60; k++) begin
      arm_load(int'($urandom_range(400, 30)), int'($urandom_range(300, 0)));
      if ($urandom_range(3, 0) == 0) begin
        idle(int'($urandom_range(300, 1)));
        sync_in = 1'b1; idle(1); sync_in = 1'b0;
      end
      idle(int'($urandom_range(700, 1)));
    end
    chk(ov_cnt == 0, "R12", "cycles with both gates high", ov_cnt, 0);
    chk(flag_bad == 0, "R12", "flag mismatches", flag_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule